// File: doc/BRIEF.md
# Security attribution region unit

This block decides, for any address presented to it, whether that address belongs to Secure, Non-Secure or Non-Secure Callable memory. It keeps a parameterised number of address regions. Each region has a 32-byte-aligned start address, an inclusive end address at the same granularity, an enable bit and a callable bit. A lookup port classifies an address in the same cycle. It also reports whether an enabled region matched and which region number was the lowest to match.

Software programs the unit through a word-wide register port addressed by a small word index. The per-region start and end registers are not mapped directly. A selector register picks which region these two registers read and write, so the number of register words stays fixed whatever the region count. A global control word turns the unit on. While the unit is off, the same word can mark all memory Non-Secure.

Top module: `sec_attr_unit`

## Requirements
- R1: After reset the control word, the selector and every region's start, end, enable and callable fields are zero. The lookup then reports attribute Secure (code 0), no hit, and region 0.
- R2: Word index 1 is read-only. Bits 7:0 return NUM_REGIONS and all other bits read 0. Writes to it change nothing.
- R3: In the control word (index 0), bit 0 enables the unit and bit 1 selects all-Non-Secure. While bit 0 is clear, the lookup reports Non-Secure (code 1) if bit 1 is set and Secure (code 0) if it is clear, with no hit and region 0. While bit 0 is set, bit 1 has no effect.
- R4: Index 2 holds the 8-bit selector in bits 7:0. Index 3 and index 4 read and write the start and end registers of the selected region. The start register reads as address bits 31:5 with bits 4:0 zero. The end register reads as address bits 31:5 in bits 31:5, the callable bit in bit 1, the enable bit in bit 0, and zero in bits 4:2.
- R5: While the selector is at or above NUM_REGIONS, writes to index 3 and index 4 change no region, and reads of them return 0.
- R6: An address matches a region when the region is enabled and the address is at or above its start and at or below its end with bits 4:0 taken as all ones. Disabled regions never match.
- R7: With the unit enabled, one matching region yields Non-Secure (code 1) when its callable bit is clear and Non-Secure Callable (code 2) when it is set, with hit high and that region's number. No match yields Secure (code 0), hit low and region 0.
- R8: With the unit enabled, an address that matches two or more regions yields Secure (code 0), hit high, and the number of the lowest-numbered matching region.
- R9: Word indices 5, 6 and 7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 3 | Register word index |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the indexed word (combinational) |
| chk_addr | input | 32 | Address to classify |
| chk_attr | output | 2 | Attribute: 0 Secure, 1 Non-Secure, 2 Non-Secure Callable |
| chk_hit | output | 1 | At least one enabled region matched |
| chk_region | output | 8 | Lowest matching region number, 0 when no hit |

## Verification
The embedded assertions are checked on every cycle. They cover four properties: an overlap always resolves to Secure with a hit, a missing match never reports a hit, a disabled unit never reports a hit, and the reported region really is one of the matching regions. They also check that a write with an out-of-range selector leaves all region storage unchanged. Exact boundary behaviour can only be shown by the bench's scenarios and its behavioural model. This covers the last byte of an end granule against the first byte after it, and the read-back layout of the start and end words. It also covers the callable decode and the interaction of the control bits.

// File: rtl/sau_pkg.sv
package sau_pkg;

   typedef enum logic [1:0] {
      ATTR_SECURE = 2'd0,
      ATTR_NONSEC = 2'd1,
      ATTR_NSC    = 2'd2
   } attr_e;

   localparam logic [2:0] SEL_CTRL  = 3'd0;
   localparam logic [2:0] SEL_TYPE  = 3'd1;
   localparam logic [2:0] SEL_RNUM  = 3'd2;
   localparam logic [2:0] SEL_BASE  = 3'd3;
   localparam logic [2:0] SEL_LIMIT = 3'd4;

   localparam int RNUM_W = 8;

endpackage

// File: rtl/sau_cfg_regs.sv
module sau_cfg_regs
   import sau_pkg::*;
#(
   parameter int NUM_REGIONS = 8,
   parameter int ADDR_W      = 32,
   parameter int GRAN_BITS   = 5,
   localparam int GW         = ADDR_W - GRAN_BITS,
   localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [2:0]                      reg_sel,
   input  logic                            reg_wr,
   input  logic [ADDR_W-1:0]               reg_wdata,
   output logic [ADDR_W-1:0]               reg_rdata,
   output logic                            unit_en,
   output logic                            all_ns,
   output logic [NUM_REGIONS-1:0][GW-1:0]  rgn_base,
   output logic [NUM_REGIONS-1:0][GW-1:0]  rgn_limit,
   output logic [NUM_REGIONS-1:0]          rgn_nsc,
   output logic [NUM_REGIONS-1:0]          rgn_en
);

   localparam logic [RNUM_W-1:0] NREG_L = RNUM_W'(NUM_REGIONS);

   logic [RNUM_W-1:0] rnum_q;
   logic              en_q;
   logic              allns_q;
   logic              sel_ok;
   logic [IDX_W-1:0]  sel_idx;
   logic              wr_rgn;
   logic              unused_wbits;

   assign sel_ok  = (rnum_q < NREG_L);
   assign sel_idx = rnum_q[IDX_W-1:0];
   assign wr_rgn  = reg_wr && sel_ok &&
                    ((reg_sel == SEL_BASE) || (reg_sel == SEL_LIMIT));
   assign unused_wbits = ^reg_wdata[GRAN_BITS-1:2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rnum_q  <= '0;
         en_q    <= 1'b0;
         allns_q <= 1'b0;
      end else if (reg_wr) begin
         if (reg_sel == SEL_CTRL) begin
            en_q    <= reg_wdata[0];
            allns_q <= reg_wdata[1];
         end
         if (reg_sel == SEL_RNUM) begin
            rnum_q <= reg_wdata[RNUM_W-1:0];
         end
      end
   end

   assign unit_en = en_q;
   assign all_ns  = allns_q;

   for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_rgn
      logic [GW-1:0] base_q;
      logic [GW-1:0] lim_q;
      logic          nsc_q;
      logic          ena_q;
      logic          hit_sel;

      assign hit_sel = wr_rgn && (sel_idx == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_q <= '0;
            lim_q  <= '0;
            nsc_q  <= 1'b0;
            ena_q  <= 1'b0;
         end else if (hit_sel) begin
            if (reg_sel == SEL_BASE) begin
               base_q <= reg_wdata[ADDR_W-1:GRAN_BITS];
            end else begin
               lim_q <= reg_wdata[ADDR_W-1:GRAN_BITS];
               nsc_q <= reg_wdata[1];
               ena_q <= reg_wdata[0];
            end
         end
      end

      assign rgn_base[i]  = base_q;
      assign rgn_limit[i] = lim_q;
      assign rgn_nsc[i]   = nsc_q;
      assign rgn_en[i]    = ena_q;
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_sel)
         SEL_CTRL:  reg_rdata[1:0] = {allns_q, en_q};
         SEL_TYPE:  reg_rdata[RNUM_W-1:0] = NREG_L;
         SEL_RNUM:  reg_rdata[RNUM_W-1:0] = rnum_q;
         SEL_BASE: begin
            if (sel_ok) begin
               reg_rdata[ADDR_W-1:GRAN_BITS] = rgn_base[sel_idx];
            end
         end
         SEL_LIMIT: begin
            if (sel_ok) begin
               reg_rdata[ADDR_W-1:GRAN_BITS] = rgn_limit[sel_idx];
               reg_rdata[1] = rgn_nsc[sel_idx];
               reg_rdata[0] = rgn_en[sel_idx];
            end
         end
         default: reg_rdata = '0;
      endcase
   end

   // R5: a write while the selector is out of range leaves all region storage alone
   assert_oor_write_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !sel_ok) |=> ($stable(rgn_base) && $stable(rgn_limit)
                               && $stable(rgn_nsc) && $stable(rgn_en)));

   // R4: a selector write lands in the selector register
   assert_rnum_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel == SEL_RNUM) |=> (rnum_q == $past(reg_wdata[RNUM_W-1:0])));

   // R2: the count word is fixed whatever is written
   assert_type_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel == SEL_TYPE) |-> (reg_rdata == ADDR_W'(NUM_REGIONS)));

endmodule

// File: rtl/sau_region_match.sv
module sau_region_match #(
   parameter int NUM_REGIONS = 8,
   parameter int GW          = 27
) (
   input  logic [GW-1:0]                   addr_gran,
   input  logic [NUM_REGIONS-1:0][GW-1:0]  rgn_base,
   input  logic [NUM_REGIONS-1:0][GW-1:0]  rgn_limit,
   input  logic [NUM_REGIONS-1:0]          rgn_en,
   output logic [NUM_REGIONS-1:0]          hit_vec
);

   for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_cmp
      logic above_lo;
      logic below_hi;
      assign above_lo   = (addr_gran >= rgn_base[i]);
      assign below_hi   = (addr_gran <= rgn_limit[i]);
      assign hit_vec[i] = rgn_en[i] && above_lo && below_hi;
   end

endmodule

// File: rtl/sau_attr_resolve.sv
module sau_attr_resolve
   import sau_pkg::*;
#(
   parameter int NUM_REGIONS = 8,
   localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     unit_en,
   input  logic                     all_ns,
   input  logic [NUM_REGIONS-1:0]   hit_vec,
   input  logic [NUM_REGIONS-1:0]   rgn_nsc,
   output attr_e                    attr,
   output logic                     valid,
   output logic [RNUM_W-1:0]        region
);

   logic [IDX_W-1:0] first_idx;
   logic             found;
   logic             multi;

   always_comb begin
      first_idx = '0;
      found     = 1'b0;
      multi     = 1'b0;
      for (int i = 0; i < NUM_REGIONS; i++) begin
         if (hit_vec[i]) begin
            if (found) begin
               multi = 1'b1;
            end else begin
               found     = 1'b1;
               first_idx = IDX_W'(i);
            end
         end
      end
   end

   always_comb begin
      attr   = ATTR_SECURE;
      valid  = 1'b0;
      region = '0;
      if (!unit_en) begin
         attr = all_ns ? ATTR_NONSEC : ATTR_SECURE;
      end else if (found) begin
         valid  = 1'b1;
         region = RNUM_W'(first_idx);
         if (multi) begin
            attr = ATTR_SECURE;
         end else begin
            attr = rgn_nsc[first_idx] ? ATTR_NSC : ATTR_NONSEC;
         end
      end
   end

   // R8: overlapping enabled regions never grant a non-secure attribute
   assert_overlap_secure_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (unit_en && $countones(hit_vec) > 1) |-> (attr == ATTR_SECURE && valid));

   // R7: no comparator fired means Secure without a hit
   assert_miss_secure_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (unit_en && hit_vec == '0) |-> (attr == ATTR_SECURE && !valid && region == '0));

   // R3: a switched-off unit never reports a matching region
   assert_off_no_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!unit_en) |-> (!valid && region == '0));

   // R6: the reported region is one whose comparator fired
   assert_region_matches_R6: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> hit_vec[region[IDX_W-1:0]]);

endmodule

// File: rtl/sec_attr_unit.sv
module sec_attr_unit
   import sau_pkg::*;
#(
   parameter int NUM_REGIONS = 8,
   parameter int ADDR_W      = 32,
   parameter int GRAN_BITS   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        reg_sel,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_wdata,
   output logic [ADDR_W-1:0] reg_rdata,
   input  logic [ADDR_W-1:0] chk_addr,
   output logic [1:0]        chk_attr,
   output logic              chk_hit,
   output logic [7:0]        chk_region
);

   localparam int GW = ADDR_W - GRAN_BITS;

   if (NUM_REGIONS < 1 || NUM_REGIONS > 255) begin : g_bad_count
      $error("NUM_REGIONS must lie in 1..255");
   end
   if (GRAN_BITS < 2 || GRAN_BITS >= ADDR_W) begin : g_bad_gran
      $error("GRAN_BITS must be at least 2 and below ADDR_W");
   end
   if (ADDR_W < RNUM_W) begin : g_bad_width
      $error("ADDR_W must hold the 8-bit selector field");
   end

   logic                           unit_en;
   logic                           all_ns;
   logic [NUM_REGIONS-1:0][GW-1:0] rgn_base;
   logic [NUM_REGIONS-1:0][GW-1:0] rgn_limit;
   logic [NUM_REGIONS-1:0]         rgn_nsc;
   logic [NUM_REGIONS-1:0]         rgn_en;
   logic [NUM_REGIONS-1:0]         hit_vec;
   attr_e                          attr;
   logic                           unused_abits;

   assign unused_abits = ^chk_addr[GRAN_BITS-1:0];

   sau_cfg_regs #(
      .NUM_REGIONS (NUM_REGIONS),
      .ADDR_W      (ADDR_W),
      .GRAN_BITS   (GRAN_BITS)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_sel   (reg_sel),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .unit_en   (unit_en),
      .all_ns    (all_ns),
      .rgn_base  (rgn_base),
      .rgn_limit (rgn_limit),
      .rgn_nsc   (rgn_nsc),
      .rgn_en    (rgn_en)
   );

   sau_region_match #(
      .NUM_REGIONS (NUM_REGIONS),
      .GW          (GW)
   ) u_match (
      .addr_gran (chk_addr[ADDR_W-1:GRAN_BITS]),
      .rgn_base  (rgn_base),
      .rgn_limit (rgn_limit),
      .rgn_en    (rgn_en),
      .hit_vec   (hit_vec)
   );

   sau_attr_resolve #(
      .NUM_REGIONS (NUM_REGIONS)
   ) u_resolve (
      .clk     (clk),
      .rst_n   (rst_n),
      .unit_en (unit_en),
      .all_ns  (all_ns),
      .hit_vec (hit_vec),
      .rgn_nsc (rgn_nsc),
      .attr    (attr),
      .valid   (chk_hit),
      .region  (chk_region)
   );

   assign chk_attr = attr;

endmodule

// File: tb/sec_attr_unit_tb.sv
module sec_attr_unit_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NR = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  reg_sel = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [31:0] chk_addr = '0;
   logic [1:0]  chk_attr;
   logic        chk_hit;
   logic [7:0]  chk_region;

   int n_chk = 0;
   int n_err = 0;
   bit run   = 1'b0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sec_attr_unit #(.NUM_REGIONS(NR)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .chk_addr(chk_addr),
      .chk_attr(chk_attr), .chk_hit(chk_hit), .chk_region(chk_region)
   );

   // behavioural reference state
   logic [1:0]  m_ctrl;
   logic [7:0]  m_rnum;
   logic [31:0] m_lo  [NR];
   logic [31:0] m_hi  [NR];
   bit          m_nsc [NR];
   bit          m_en  [NR];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ctrl = 0;
         m_rnum = 0;
         for (int i = 0; i < NR; i++) begin
            m_lo[i] = 0; m_hi[i] = 32'h1f; m_nsc[i] = 0; m_en[i] = 0;
         end
      end else if (reg_wr) begin
         if (reg_sel == 0) m_ctrl = reg_wdata[1:0];
         if (reg_sel == 2) m_rnum = reg_wdata[7:0];
         if (reg_sel == 3 && m_rnum < NR) m_lo[m_rnum] = {reg_wdata[31:5], 5'h00};
         if (reg_sel == 4 && m_rnum < NR) begin
            m_hi[m_rnum]  = {reg_wdata[31:5], 5'h1f};
            m_nsc[m_rnum] = reg_wdata[1];
            m_en[m_rnum]  = reg_wdata[0];
         end
      end
   end

   function automatic logic [31:0] m_read(input logic [2:0] s);
      case (s)
         3'd0: return {30'd0, m_ctrl};
         3'd1: return NR;
         3'd2: return {24'd0, m_rnum};
         3'd3: return (m_rnum < NR) ? m_lo[m_rnum] : 32'd0;
         3'd4: return (m_rnum < NR) ?
                  {m_hi[m_rnum][31:5], 3'd0, m_nsc[m_rnum], m_en[m_rnum]} : 32'd0;
         default: return 32'd0;
      endcase
   endfunction

   function automatic logic [10:0] m_look(input logic [31:0] a);
      int cnt = 0;
      int first = 0;
      logic [1:0] at;
      if (m_ctrl[0] == 1'b0) return {(m_ctrl[1] ? 2'd1 : 2'd0), 1'b0, 8'd0};
      for (int i = NR - 1; i >= 0; i--) begin
         if (m_en[i] && a >= m_lo[i] && a <= m_hi[i]) begin
            cnt++;
            first = i;
         end
      end
      if (cnt == 0) return 11'd0;
      if (cnt > 1) at = 2'd0;
      else at = m_nsc[first] ? 2'd2 : 2'd1;
      return {at, 1'b1, 8'(first)};
   endfunction

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && run) begin
         check("R4 R5 R9 read word", reg_rdata, m_read(reg_sel));
         check("R6 R7 R8 lookup", {21'd0, chk_attr, chk_hit, chk_region},
               {21'd0, m_look(chk_addr)});
      end
   end

   task automatic wr(input logic [2:0] s, input logic [31:0] d);
      @(negedge clk); #1;
      reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] s, input logic [31:0] exp, input string tag);
      @(negedge clk); #1;
      reg_sel = s;
      @(negedge clk);
      check(tag, reg_rdata, exp);
   endtask

   task automatic probe(input logic [31:0] a, input logic [1:0] at, input logic h,
                        input logic [7:0] r, input string tag);
      @(negedge clk); #1;
      chk_addr = a;
      @(negedge clk);
      check(tag, {21'd0, chk_attr, chk_hit, chk_region}, {21'd0, at, h, r});
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset lookup", {21'd0, chk_attr, chk_hit, chk_region}, 32'd0);
      check("R1 reset ctrl", reg_rdata, 32'd0);
      #1 rst_n = 1'b1;
      run = 1'b1;

      rd(3'd1, 32'd8, "R2 type count");
      wr(3'd1, 32'hFFFF_FFFF);
      rd(3'd1, 32'd8, "R2 type write ignored");
      rd(3'd3, 32'd0, "R1 reset base");

      wr(3'd0, 32'h2);
      probe(32'h0000_2000, 2'd1, 1'b0, 8'd0, "R3 off with all-NS");
      wr(3'd0, 32'h0);
      probe(32'h0000_2000, 2'd0, 1'b0, 8'd0, "R3 off secure");

      wr(3'd2, 0); wr(3'd3, 32'h0000_1000); wr(3'd4, 32'h0000_1FE1);
      wr(3'd2, 1); wr(3'd3, 32'h0000_3000); wr(3'd4, 32'h0000_30E3);
      wr(3'd2, 2); wr(3'd3, 32'h0000_1800); wr(3'd4, 32'h0000_37E1);
      wr(3'd2, 3); wr(3'd3, 32'h0000_8000); wr(3'd4, 32'h0000_8FE0);
      wr(3'd2, 1);
      rd(3'd3, 32'h0000_3000, "R4 base readback");
      rd(3'd4, 32'h0000_30E3, "R4 limit readback");
      wr(3'd0, 32'h1);

      probe(32'h0000_1000, 2'd1, 1'b1, 8'd0, "R6 base edge");
      probe(32'h0000_17FF, 2'd1, 1'b1, 8'd0, "R7 single NS");
      probe(32'h0000_1800, 2'd0, 1'b1, 8'd0, "R8 overlap 0 and 2");
      probe(32'h0000_2000, 2'd1, 1'b1, 8'd2, "R7 region 2");
      probe(32'h0000_3000, 2'd0, 1'b1, 8'd1, "R8 overlap 1 and 2");
      probe(32'h0000_37FF, 2'd1, 1'b1, 8'd2, "R6 limit low bits ones");
      probe(32'h0000_3800, 2'd0, 1'b0, 8'd0, "R6 past limit");
      probe(32'h0000_0FFF, 2'd0, 1'b0, 8'd0, "R6 below base");
      probe(32'h0000_8000, 2'd0, 1'b0, 8'd0, "R6 disabled region");

      wr(3'd2, 2); wr(3'd4, 32'h0000_37E0);
      probe(32'h0000_3000, 2'd2, 1'b1, 8'd1, "R7 callable");
      probe(32'h0000_30FF, 2'd2, 1'b1, 8'd1, "R7 callable end");
      probe(32'h0000_3100, 2'd0, 1'b0, 8'd0, "R7 miss secure");

      wr(3'd2, 9);
      wr(3'd3, 32'h0000_5000); wr(3'd4, 32'h0000_5FE1);
      rd(3'd3, 32'd0, "R5 base reads zero");
      rd(3'd4, 32'd0, "R5 limit reads zero");
      rd(3'd2, 32'd9, "R4 selector value");
      probe(32'h0000_5000, 2'd0, 1'b0, 8'd0, "R5 no region created");
      for (int k = 0; k < NR; k++) begin
         wr(3'd2, k);
         rd(3'd3, m_read(3'd3), "R5 regions untouched");
      end
      wr(3'd2, 1);
      rd(3'd3, 32'h0000_3000, "R5 region 1 kept");

      wr(3'd5, 32'hFFFF_FFFF); wr(3'd7, 32'hFFFF_FFFF);
      rd(3'd5, 32'd0, "R9 index 5");
      rd(3'd6, 32'd0, "R9 index 6");
      rd(3'd7, 32'd0, "R9 index 7");
      rd(3'd0, 32'd1, "R9 ctrl unchanged");

      wr(3'd0, 32'h3);
      probe(32'h0000_0000, 2'd0, 1'b0, 8'd0, "R3 all-NS ignored when on");
      wr(3'd0, 32'h0);
      probe(32'h0000_1000, 2'd0, 1'b0, 8'd0, "R3 off ignores regions");
      wr(3'd0, 32'h1);

      for (int n = 0; n < 2000; n++) begin
         @(negedge clk); #1;
         reg_sel   = 3'($urandom_range(0, 7));
         reg_wr    = ($urandom_range(0, 3) == 0);
         chk_addr  = 32'($urandom_range(0, 32'h9FFF));
         if (reg_sel == 3'd2) reg_wdata = 32'($urandom_range(0, 11));
         else if (reg_sel == 3'd0) reg_wdata = (($urandom_range(0, 7) == 0) ? 32'd2 : 32'd1);
         else reg_wdata = 32'($urandom_range(0, 32'h9FFF));
      end
      @(negedge clk); #1 reg_wr = 1'b0;
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule